// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations for a 32-bit address space divided into 4 KB pages. Each request presents a virtual address and an access kind. The upper 20 bits (the virtual page number) are compared against the tag of every valid entry in the same cycle. A translation may sit in any entry.

On a match, the block checks the entry's two permission bits against the access kind. If the access is allowed, the block returns the stored 20-bit frame number joined to the unchanged 12-bit offset. If it is refused, the block reports a protection fault. A request that matches nothing reports a miss. The page-table walker or software then loads the translation through a refill port.

Each entry also keeps a referenced flag and a written flag, so that page-replacement and write-back software can use them. A flush input drops every translation in one cycle, for use when the address space changes. The result of each lookup is registered and appears one cycle after the request.

Top module: `xlate_buf`

## Requirements
- R1: A request whose page number matches no valid entry gives `rsp_miss` with `rsp_paddr` zero. A refill written in the same cycle as a lookup is not visible to that lookup; it becomes visible to the next one.
- R2: On a permitted hit, `rsp_paddr` is the entry's frame number in bits 31:12 and the request's offset unchanged in bits 11:0.
- R3: The result of a request sampled at one rising edge is visible right after that edge. When a request was made, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. With no request, all three are low.
- R4: Permission codes are 00 read-only, 01 read-write, 10 execute-only and 11 read-write-execute. A write (`req_kind` 01) to an entry coded 00 or 10 gives `rsp_fault`, even though the entry is valid, and `rsp_paddr` is zero on any fault.
- R5: A fetch (`req_kind` 10) is allowed only when permission bit 1 is set (codes 10 and 11). A read (`req_kind` 00, or the spare code 11) is refused only on execute-only entries.
- R6: On a hit, `rsp_ref` and `rsp_mod` show the entry's referenced and written flags as they were before the access. A permitted access sets the referenced flag, and a permitted write also sets the written flag. A refill clears both flags. A faulting access changes neither flag.
- R7: A refill goes to the lowest-numbered invalid entry. When every entry is valid, it replaces the entry named by a rotating pointer, which starts at entry 0 after reset and advances by one after each such replacement.
- R8: `flush` invalidates every entry in one cycle. A refill presented in the same cycle as `flush` is discarded.
- R9: During and right after reset, all result outputs are zero and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 treated as read |
| rsp_hit | output | 1 | Registered: translation found and permitted |
| rsp_miss | output | 1 | Registered: no valid entry matched |
| rsp_fault | output | 1 | Registered: entry matched but access refused |
| rsp_paddr | output | 32 | Registered physical address, zero unless hit |
| rsp_ref | output | 1 | Registered referenced flag of the matched entry before access |
| rsp_mod | output | 1 | Registered written flag of the matched entry before access |
| fill_valid | input | 1 | Load a translation this cycle |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_prot | input | 2 | Permission code of the new entry |
| flush | input | 1 | Invalidate all entries |

## Verification
Each lookup result is due one clock after the edge that sampled the request. Refills and flushes take effect at their own edge, so they show up in the first lookup made after it. The bench drives every input on a falling edge and reads the result registers on the next falling edge, which is half a period after the edge that loaded them. To make the state changes visible, the bench follows each refill, flush or access with a lookup; ordering effects are seen through the flag and hit/miss outputs of later lookups, never through internal state. An idle falling edge after each lookup confirms that the result clears when there is no request.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_SPARE = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    PERM_RO  = 2'b00,
    PERM_RW  = 2'b01,
    PERM_XO  = 2'b10,
    PERM_RWX = 2'b11
  } perm_e;

  function automatic logic perm_ok(input logic [1:0] perm, input logic [1:0] kind);
    case (kind)
      ACC_WRITE: perm_ok = perm[0];
      ACC_FETCH: perm_ok = perm[1];
      default:   perm_ok = (perm != PERM_XO);
    endcase
  endfunction
endpackage

// File: rtl/xlb_match.sv
module xlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [VPN_W-1:0]              vpn,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            vld,
  output logic                          hit_any,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/xlb_victim.sv
module xlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] vld,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign idx = free_any ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (fill_go && !free_any)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (rst)
    (!(&vld)) |-> !vld[idx]); // R7
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int VA_W   = VPN_W + OFS_W,
  localparam int PA_W   = PFN_W + OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_ref,
  output logic             rsp_mod,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_prot,
  input  logic             flush
);
  import xlb_pkg::*;

  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  logic [ENTRIES-1:0][1:0]       perm_q;
  logic [ENTRIES-1:0]            vld_q, ref_q, mod_q;

  logic             hit_any, allow, fill_go;
  logic [IDX_W-1:0] hit_idx, fill_idx;
  logic [VPN_W-1:0] req_vpn;
  logic [OFS_W-1:0] req_ofs;

  assign req_vpn = req_vaddr[VA_W-1:OFS_W];
  assign req_ofs = req_vaddr[OFS_W-1:0];
  assign fill_go = fill_valid && !flush;

  xlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .vpn(req_vpn), .tags(tag_q), .vld(vld_q),
    .hit_any(hit_any), .hit_idx(hit_idx)
  );

  xlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .vld(vld_q), .fill_go(fill_go), .idx(fill_idx)
  );

  assign allow = perm_ok(perm_q[hit_idx], req_kind);

  // Registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_ref   <= 1'b0;
      rsp_mod   <= 1'b0;
    end else begin
      rsp_hit   <= req_valid && hit_any && allow;
      rsp_fault <= req_valid && hit_any && !allow;
      rsp_miss  <= req_valid && !hit_any;
      rsp_paddr <= (req_valid && hit_any && allow) ? {pfn_q[hit_idx], req_ofs} : '0;
      rsp_ref   <= req_valid && hit_any && ref_q[hit_idx];
      rsp_mod   <= req_valid && hit_any && mod_q[hit_idx];
    end
  end

  // Entry state: flush, status update, refill (refill last so it wins)
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ref_q <= '0;
      mod_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (req_valid && hit_any && allow) begin
        ref_q[hit_idx] <= 1'b1;
        if (req_kind == ACC_WRITE) mod_q[hit_idx] <= 1'b1;
      end
      if (fill_go) begin
        vld_q[fill_idx] <= 1'b1;
        ref_q[fill_idx] <= 1'b0;
        mod_q[fill_idx] <= 1'b0;
      end
    end
  end

  // Payload storage: no reset needed
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_idx]  <= fill_vpn;
      pfn_q[fill_idx]  <= fill_pfn;
      perm_q[fill_idx] <= fill_prot;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit || rsp_miss || rsp_fault) |-> $onehot({rsp_hit, rsp_miss, rsp_fault})); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_hit || rsp_miss || rsp_fault)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_paddr == '0)); // R1
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_ofs))); // R2
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (req_valid |=> rsp_miss)); // R8
endmodule

// File: tb/tb_xlate_buf.sv
`timescale 1ns/1ps
module tb_xlate_buf;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod;
  logic [31:0] rsp_paddr;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [1:0]  fill_prot;
  logic        flush;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10;
  localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FLT = 3'b001, NONE = 3'b000;

  always #4 clk = ~clk;

  xlate_buf dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref),
    .rsp_mod(rsp_mod), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_prot(fill_prot), .flush(flush)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finish_run();
    end
  end

  // One lookup; result read on the falling edge after the sampling edge
  task automatic lookup(input string tag, input logic [31:0] va, input logic [1:0] kind,
                        input logic [2:0] exp_res, input logic [31:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " result"}, {29'd0, rsp_hit, rsp_miss, rsp_fault}, {29'd0, exp_res});
    check({tag, " paddr"}, rsp_paddr, exp_pa);
  endtask

  task automatic lookup_flags(input string tag, input logic [31:0] va, input logic [1:0] kind,
                              input logic exp_ref, input logic exp_mod);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " ref/mod"}, {30'd0, rsp_ref, rsp_mod}, {30'd0, exp_ref, exp_mod});
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] prot);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset outputs", {26'd0, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod, 1'b0}, 32'd0);
    check("R9 reset paddr", rsp_paddr, 32'd0);
    lookup("R9 empty after reset", 32'h0000_0000, RD, MISS, 32'd0);
  endtask

  task automatic t_basic();
    lookup("R1 miss", 32'h1234_5678, RD, MISS, 32'd0);
    fill(20'h12345, 20'hABCDE, 2'b01);
    lookup("R2 hit read", 32'h1234_5678, RD, HIT, 32'hABCD_E678);
    lookup("R2 hit other offset", 32'h1234_5FFF, RD, HIT, 32'hABCD_EFFF);
    @(negedge clk);
    check("R3 idle quiet", {29'd0, rsp_hit, rsp_miss, rsp_fault}, {29'd0, NONE});
  endtask

  task automatic t_flags();
    fill(20'h00040, 20'h00400, 2'b01);
    lookup_flags("R6 first read", 32'h0004_0010, RD, 1'b0, 1'b0);
    lookup_flags("R6 second read", 32'h0004_0010, RD, 1'b1, 1'b0);
    lookup_flags("R6 write", 32'h0004_0010, WR, 1'b1, 1'b0);
    lookup_flags("R6 after write", 32'h0004_0010, RD, 1'b1, 1'b1);
  endtask

  task automatic t_protect();
    fill(20'h00001, 20'h00111, 2'b00);
    lookup("R4 write read-only", 32'h0000_1004, WR, FLT, 32'd0);
    lookup_flags("R6 fault leaves flags", 32'h0000_1004, RD, 1'b0, 1'b0);
    lookup("R5 fetch read-only", 32'h0000_1004, FE, FLT, 32'd0);
    lookup("R5 fetch read-write", 32'h1234_5000, FE, FLT, 32'd0);
    fill(20'h00002, 20'h00222, 2'b10);
    lookup("R5 fetch exec-only", 32'h0000_2ABC, FE, HIT, 32'h0022_2ABC);
    lookup("R5 read exec-only", 32'h0000_2ABC, RD, FLT, 32'd0);
    lookup("R4 write exec-only", 32'h0000_2ABC, WR, FLT, 32'd0);
    fill(20'h00003, 20'h00333, 2'b11);
    lookup("R5 read rwx", 32'h0000_3001, RD, HIT, 32'h0033_3001);
    lookup("R5 write rwx", 32'h0000_3002, WR, HIT, 32'h0033_3002);
    lookup("R5 fetch rwx", 32'h0000_3003, FE, HIT, 32'h0033_3003);
    lookup("R5 spare kind as read", 32'h0000_3004, 2'b11, HIT, 32'h0033_3004);
  endtask

  task automatic t_replace();
    // entries 0..4 hold 12345,00040,00001,00002,00003
    for (int i = 0; i < 3; i++) fill(20'h00010 + 20'(i), 20'h01000 + 20'(i), 2'b01);
    lookup("R7 all filled", 32'h0001_2000, RD, HIT, 32'h0100_2000);
    fill(20'h00020, 20'h02000, 2'b01);
    lookup("R7 rr evicts entry0", 32'h1234_5000, RD, MISS, 32'd0);
    lookup("R7 new entry hits", 32'h0002_0000, RD, HIT, 32'h0200_0000);
    lookup("R7 entry2 kept", 32'h0000_1000, RD, HIT, 32'h0011_1000);
    fill(20'h00021, 20'h02100, 2'b01);
    lookup("R7 rr evicts entry1", 32'h0004_0000, RD, MISS, 32'd0);
    lookup("R7 entry2 still kept", 32'h0000_1000, RD, HIT, 32'h0011_1000);
  endtask

  task automatic t_same_cycle_fill();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_4008; req_kind = RD;
    fill_valid = 1'b1; fill_vpn = 20'h00004; fill_pfn = 20'h00444; fill_prot = 2'b01;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    check("R1 same-cycle fill unseen", {29'd0, rsp_hit, rsp_miss, rsp_fault}, {29'd0, MISS});
    lookup("R1 fill seen next", 32'h0000_4008, RD, HIT, 32'h0044_4008);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00050; fill_pfn = 20'h00555; fill_prot = 2'b01;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup("R8 flushed entry", 32'h0000_3000, RD, MISS, 32'd0);
    lookup("R8 flushed entry b", 32'h0002_0000, RD, MISS, 32'd0);
    lookup("R8 fill with flush dropped", 32'h0005_0000, RD, MISS, 32'd0);
    fill(20'h00060, 20'h00666, 2'b01);
    fill(20'h00061, 20'h00667, 2'b01);
    lookup("R7 refill after flush a", 32'h0006_0123, RD, HIT, 32'h0066_6123);
    lookup("R7 refill after flush b", 32'h0006_1123, RD, HIT, 32'h0066_7123);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = RD;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_prot = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_flags();
    t_protect();
    t_replace();
    t_same_cycle_fill();
    t_flush();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule